// File: doc/BRIEF.md
# Series-Parallel Reconfiguration Switch Sequencer

This block drives the seven switch gates of a four-cell storage module that can regroup its cells in series and in parallel. It takes four digitised cell-voltage codes and averages them. It then compares the average with two programmable thresholds and picks one of three groupings: two cells in series by two in parallel, three in series, or four in series. In the middle grouping it keeps rotating through three switch arrangements at the tick rate, so that every cell carries the same share of current over time. A direction input tells the block whether the module is being charged or discharged. Groupings only move one way per direction, so a noisy reading cannot send the module back.

Every change of switch arrangement passes through a dead-time phase that lasts one tick. In that phase only the switches that the old and new arrangements share are on. All decisions are taken on tick boundaries. The tick comes from an internal divider of the system clock, and its default gives a four-per-second rate at 200 MHz. A status output gives the current mode, the sub-mode and a dead-time flag.

Top module: `sp_reconfig_seq`

## Requirements
- R1: While reset is asserted, and after it, until the block starts, gate_o is 0, mode_o is 0, sub_o is 0 and dead_o is 0.
- R2: The average VC is floor(sum of the NCELL codes / NCELL). It is captured on every clock where codes_vld_i is high. Before the first capture the block stays idle with all gates off.
- R3: The target mode is 1 when VC >= th_upper_i, 2 when th_lower_i <= VC < th_upper_i, and 3 when VC < th_lower_i. All values are unsigned codes.
- R4: At the first tick after a valid average exists, the block enters dead time with all gates off, showing the target mode. At the next tick it applies that mode's pattern.
- R5: gate_o bit k drives switch k+1. The patterns are: mode 1 = 7'h5D, mode 3 = 7'h2A, sub-mode A = 7'h5A, sub-mode B = 7'h36, sub-mode C = 7'h2D.
- R6: Every pattern change goes through one dead-time tick. In that tick dead_o is 1 and gate_o is the bitwise AND of the old and new patterns. mode_o and sub_o already show the destination.
- R7: With charge_i = 0 (discharge) the mode only moves from 1 to 2 to 3. With charge_i = 1 (charge) it only moves from 3 to 2 to 1. A target in the other direction is ignored.
- R8: A mode step happens at a tick only outside dead time, and only when the step condition held at this tick and at the previous tick. Each step moves one mode. A condition that lasts a single tick has no effect.
- R9: In mode 2 each sub-mode lasts one tick, followed by a dead tick. Sub-modes rotate A, B, C, A when discharging and C, B, A, C when charging.
- R10: Mode 2 is entered at A when discharging and at C when charging, and it can be left from any sub-mode. sub_o is 1 for A, 2 for B, 3 for C, and 0 outside mode 2.
- R11: A tick occurs once every TICK_DIV clocks (TICK_DIV >= 2), and two ticks never fall on adjacent clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_codes_i | input | NCELL*CODE_W | Packed cell-voltage codes, cell 0 in the low bits |
| codes_vld_i | input | 1 | Codes valid strobe |
| th_upper_i | input | CODE_W | Mode 1 / mode 2 boundary |
| th_lower_i | input | CODE_W | Mode 2 / mode 3 boundary |
| charge_i | input | 1 | 1 = charging, 0 = discharging |
| gate_o | output | 7 | Switch gate enables, bit k = switch k+1 |
| mode_o | output | 2 | Current or destination mode (0 before start) |
| sub_o | output | 2 | Sub-mode in mode 2 (1 A, 2 B, 3 C) |
| dead_o | output | 1 | High during a dead-time tick |

## Verification
The assertions check on every clock that gates can only drop when dead time begins and can only rise when it ends. They also check that gates never change outside those two edges, that each mode step goes one way according to the direction, that a sub-mode is reported exactly when in mode 2, that gates stay off before start, and that ticks are spaced correctly. The bench scenarios are needed to show the rest: threshold boundaries and the rounding of the average, rejection of one-tick glitches, rotation order in both directions, the entry sub-mode, and that every dead and mode-2 phase lasts one tick. A tick-level reference model feeds a scoreboard of expected output changes for these checks.

// File: rtl/rm_pkg.sv
package rm_pkg;

  localparam int NGATE = 7;

  typedef enum logic [1:0] {
    MD_NONE  = 2'd0,
    MD_ONE   = 2'd1,
    MD_TWO   = 2'd2,
    MD_THREE = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SB_NONE = 2'd0,
    SB_A    = 2'd1,
    SB_B    = 2'd2,
    SB_C    = 2'd3
  } sub_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEAD = 2'd1,
    ST_HOLD = 2'd2
  } seq_st_e;

  // switch k+1 is bit k
  function automatic logic [NGATE-1:0] gate_pattern(mode_e m, sub_e s);
    logic [NGATE-1:0] p;
    case (m)
      MD_ONE:   p = 7'h5D;
      MD_THREE: p = 7'h2A;
      MD_TWO: begin
        case (s)
          SB_A:    p = 7'h5A;
          SB_B:    p = 7'h36;
          SB_C:    p = 7'h2D;
          default: p = '0;
        endcase
      end
      default:  p = '0;
    endcase
    return p;
  endfunction

  function automatic sub_e sub_advance(sub_e s, logic chg);
    sub_e n;
    case (s)
      SB_A:    n = chg ? SB_C : SB_B;
      SB_B:    n = chg ? SB_A : SB_C;
      SB_C:    n = chg ? SB_B : SB_A;
      default: n = chg ? SB_C : SB_A;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rm_tick_gen.sv
module rm_tick_gen #(
  parameter int DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    tick_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  assert_tick_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

endmodule

// File: rtl/rm_level_eval.sv
module rm_level_eval
  import rm_pkg::*;
#(
  parameter int NCELL  = 4,
  parameter int CODE_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCELL*CODE_W-1:0] cells_i,
  input  logic                    vld_i,
  input  logic [CODE_W-1:0]       hi_i,
  input  logic [CODE_W-1:0]       lo_i,
  output mode_e                   lvl_o,
  output logic                    lvl_vld_o
);
  localparam int SH   = $clog2(NCELL);
  localparam int SUMW = CODE_W + SH;

  logic [CODE_W-1:0] code_a [NCELL];
  logic [SUMW-1:0]   sum;
  logic [CODE_W-1:0] avg_d, avg_q;
  logic              vld_q;

  for (genvar g = 0; g < NCELL; g++) begin : g_unpack
    assign code_a[g] = cells_i[g*CODE_W +: CODE_W];
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NCELL; i++) begin
      sum = sum + SUMW'(code_a[i]);
    end
    avg_d = CODE_W'(sum >> SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q <= '0;
      vld_q <= 1'b0;
    end else if (vld_i) begin
      avg_q <= avg_d;
      vld_q <= 1'b1;
    end
  end

  always_comb begin
    if (avg_q >= hi_i)      lvl_o = MD_ONE;
    else if (avg_q >= lo_i) lvl_o = MD_TWO;
    else                    lvl_o = MD_THREE;
  end

  assign lvl_vld_o = vld_q;

  assert_vld_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> vld_q);

endmodule

// File: rtl/rm_mode_fsm.sv
module rm_mode_fsm
  import rm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             charge_i,
  input  mode_e            lvl_i,
  input  logic             lvl_vld_i,
  output logic [NGATE-1:0] gate_o,
  output mode_e            mode_o,
  output sub_e             sub_o,
  output logic             dead_o
);
  seq_st_e          st_q, st_d;
  mode_e            mode_q, mode_d, nxt_mode;
  sub_e             sub_q, sub_d, entry_sub;
  logic [NGATE-1:0] pat_q, pat_d, gate_q, gate_d;
  logic             pend_q, pend_d;
  logic             step_req;

  always_comb begin
    step_req  = charge_i ? (lvl_i < mode_q) : (lvl_i > mode_q);
    nxt_mode  = charge_i ? mode_e'(mode_q - 2'd1) : mode_e'(mode_q + 2'd1);
    entry_sub = charge_i ? SB_C : SB_A;
  end

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    sub_d  = sub_q;
    pat_d  = pat_q;
    gate_d = gate_q;
    pend_d = pend_q;
    if (tick_i) begin
      case (st_q)
        ST_IDLE: begin
          if (lvl_vld_i) begin
            mode_d = lvl_i;
            sub_d  = (lvl_i == MD_TWO) ? entry_sub : SB_NONE;
            pat_d  = gate_pattern(mode_d, sub_d);
            gate_d = '0;
            pend_d = 1'b0;
            st_d   = ST_DEAD;
          end
        end
        ST_DEAD: begin
          gate_d = pat_q;
          pend_d = step_req;
          st_d   = ST_HOLD;
        end
        ST_HOLD: begin
          if (step_req && pend_q) begin
            mode_d = nxt_mode;
            sub_d  = (nxt_mode == MD_TWO) ? entry_sub : SB_NONE;
            pat_d  = gate_pattern(mode_d, sub_d);
            gate_d = gate_q & pat_d;
            pend_d = 1'b0;
            st_d   = ST_DEAD;
          end else begin
            pend_d = step_req;
            if (mode_q == MD_TWO) begin
              sub_d  = sub_advance(sub_q, charge_i);
              pat_d  = gate_pattern(mode_q, sub_d);
              gate_d = gate_q & pat_d;
              st_d   = ST_DEAD;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MD_NONE;
      sub_q  <= SB_NONE;
      pat_q  <= '0;
      gate_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      sub_q  <= sub_d;
      pat_q  <= pat_d;
      gate_q <= gate_d;
      pend_q <= pend_d;
    end
  end

  assign gate_o = gate_q;
  assign mode_o = mode_q;
  assign sub_o  = sub_q;
  assign dead_o = (st_q == ST_DEAD);

  // entering dead time may only drop switches
  assert_gate_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dead_o) |-> ((gate_o & ~$past(gate_o)) == '0));
  // leaving dead time may only add switches
  assert_gate_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dead_o) |-> ((gate_o & $past(gate_o)) == $past(gate_o)));
  assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(dead_o) && !$fell(dead_o)) |-> $stable(gate_o));
  assert_dir_dis_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o != $past(mode_o)) && ($past(mode_o) != MD_NONE) && !$past(charge_i))
      |-> (2'(mode_o) == 2'($past(mode_o)) + 2'd1));
  assert_dir_chg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o != $past(mode_o)) && ($past(mode_o) != MD_NONE) && $past(charge_i))
      |-> (2'(mode_o) + 2'd1 == 2'($past(mode_o))));
  assert_sub_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_TWO) == (sub_o != SB_NONE));
  assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_NONE) |-> (gate_o == '0 && !dead_o));

endmodule

// File: rtl/sp_reconfig_seq.sv
module sp_reconfig_seq
  import rm_pkg::*;
#(
  parameter int NCELL    = 4,
  parameter int CODE_W   = 12,
  parameter int TICK_DIV = 50_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCELL*CODE_W-1:0] cell_codes_i,
  input  logic                    codes_vld_i,
  input  logic [CODE_W-1:0]       th_upper_i,
  input  logic [CODE_W-1:0]       th_lower_i,
  input  logic                    charge_i,
  output logic [6:0]              gate_o,
  output logic [1:0]              mode_o,
  output logic [1:0]              sub_o,
  output logic                    dead_o
);
  logic [1:0] rsync_q;
  logic       srst_n;
  logic       tick;
  mode_e      lvl;
  logic       lvl_vld;
  mode_e      mode_s;
  sub_e       sub_s;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  rm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (srst_n),
    .tick_o (tick)
  );

  rm_level_eval #(.NCELL(NCELL), .CODE_W(CODE_W)) u_level (
    .clk       (clk),
    .rst_n     (srst_n),
    .cells_i   (cell_codes_i),
    .vld_i     (codes_vld_i),
    .hi_i      (th_upper_i),
    .lo_i      (th_lower_i),
    .lvl_o     (lvl),
    .lvl_vld_o (lvl_vld)
  );

  rm_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (srst_n),
    .tick_i    (tick),
    .charge_i  (charge_i),
    .lvl_i     (lvl),
    .lvl_vld_i (lvl_vld),
    .gate_o    (gate_o),
    .mode_o    (mode_s),
    .sub_o     (sub_s),
    .dead_o    (dead_o)
  );

  assign mode_o = 2'(mode_s);
  assign sub_o  = 2'(sub_s);

endmodule

// File: tb/sim_sp_reconfig_seq.sv
module sim_sp_reconfig_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DIV = 16;
  localparam int CW  = 12;
  localparam int HI  = 1600;
  localparam int LO  = 1070;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [4*CW-1:0] codes;
  logic          vld, chg;
  logic [CW-1:0] th_hi, th_lo;
  logic [6:0]    gate_o;
  logic [1:0]    mode_o, sub_o;
  logic          dead_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sp_reconfig_seq #(.NCELL(4), .CODE_W(CW), .TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cell_codes_i(codes), .codes_vld_i(vld),
    .th_upper_i(th_hi), .th_lower_i(th_lo), .charge_i(chg),
    .gate_o(gate_o), .mode_o(mode_o), .sub_o(sub_o), .dead_o(dead_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_pat(input int md, input int sb);
    if (md == 1) return 7'h5D;
    if (md == 3) return 7'h2A;
    if (md == 2 && sb == 1) return 7'h5A;
    if (md == 2 && sb == 2) return 7'h36;
    if (md == 2 && sb == 3) return 7'h2D;
    return 7'h00;
  endfunction

  // ---------------- reference model and scoreboard queue ----------------
  logic [11:0] exp_q [$];
  string       tag_q [$];
  event        tick_ev;
  int          bcnt;
  int          m_st, m_mode, m_sub, m_pend;
  logic [6:0]  m_gate;
  logic [11:0] m_last;

  function automatic int ref_avg();
    int s = 0;
    for (int i = 0; i < 4; i++) s += int'(codes[i*CW +: CW]);
    return s / 4;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      bcnt = 0; m_st = 0; m_mode = 0; m_sub = 0; m_pend = 0;
      m_gate = '0; m_last = '0;
    end else begin
      bcnt++;
      if (bcnt % DIV == DIV - 1) begin : model_step
        int    av, want_md, want;
        string tg;
        logic [11:0] tup;
        av      = ref_avg();
        want_md = (av >= HI) ? 1 : (av >= LO) ? 2 : 3;
        want    = chg ? int'(want_md < m_mode) : int'(want_md > m_mode);
        tg = "";
        if (m_st == 0) begin
          if (vld) begin
            m_mode = want_md; m_sub = (want_md == 2) ? (chg ? 3 : 1) : 0;
            m_gate = '0; m_pend = 0; m_st = 1; tg = "R4";
          end
        end else if (m_st == 1) begin
          m_gate = ref_pat(m_mode, m_sub); m_pend = want; m_st = 2; tg = "R6";
        end else begin
          if (want != 0 && m_pend != 0) begin
            m_mode = chg ? m_mode - 1 : m_mode + 1;
            m_sub  = (m_mode == 2) ? (chg ? 3 : 1) : 0;
            m_gate = m_gate & ref_pat(m_mode, m_sub);
            m_pend = 0; m_st = 1;
            tg = (m_mode == 2) ? "R10" : "R8";
          end else begin
            m_pend = want;
            if (m_mode == 2) begin
              if (chg) m_sub = (m_sub == 1) ? 3 : m_sub - 1;
              else     m_sub = (m_sub == 3) ? 1 : m_sub + 1;
              m_gate = m_gate & ref_pat(m_mode, m_sub);
              m_st = 1; tg = "R9";
            end
          end
        end
        tup = {m_gate, 2'(m_mode), 2'(m_sub), (m_st == 1)};
        if (tup != m_last) begin
          exp_q.push_back(tup);
          tag_q.push_back(tg);
          m_last = tup;
        end
        -> tick_ev;
      end
    end
  end

  // ---------------- monitor ----------------
  logic [11:0] o_last;
  logic [6:0]  o_steady;
  int          ph_len;

  always @(negedge clk) begin
    logic [11:0] cur;
    cur = {gate_o, mode_o, sub_o, dead_o};
    if (!rst_n) begin
      o_last = '0; o_steady = '0; ph_len = 0;
    end else begin
      ph_len++;
      if (cur != o_last) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected change", int'(cur), 0);
        end else begin
          logic [11:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cur == e, t, int'(cur), int'(e));
        end
        // phase length: dead ticks and mode-2 sub-modes last one tick (R9)
        if (o_last[0] || o_last[4:3] == 2'd2)
          chk(ph_len == DIV, "R9 phase length", ph_len, DIV);
        // leaving dead time: dead pattern is the AND of its neighbours (R6)
        if (o_last[0] && !cur[0]) begin
          chk(o_last[11:5] == (o_steady & cur[11:5]), "R6 overlap",
              int'(o_last[11:5]), int'(o_steady & cur[11:5]));
          o_steady = cur[11:5];
        end
        ph_len = 0;
        o_last = cur;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic idle(input int n);
    repeat (n) @(tick_ev);
    repeat (DIV/2) @(negedge clk);
  endtask

  task automatic set4(input int a, input int b, input int c, input int d);
    codes = {CW'(d), CW'(c), CW'(b), CW'(a)};
    vld   = 1'b1;
  endtask

  task automatic see_mode(input int md, input string req);
    chk(int'(mode_o) == md && !dead_o, req, int'(mode_o), md);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; vld = 1'b0; chg = 1'b0; codes = '0;
    th_hi = CW'(HI); th_lo = CW'(LO);
    repeat (3) @(negedge clk);
    chk({gate_o, mode_o, sub_o, dead_o} == '0, "R1 reset",
        int'({gate_o, mode_o, sub_o, dead_o}), 0);
    rst_n = 1'b1;

    idle(3);
    chk(gate_o == '0 && mode_o == 2'd0, "R2 no valid average", int'(gate_o), 0);

    set4(2400, 2410, 2390, 2402);
    idle(3);
    see_mode(1, "R4 start");
    chk(gate_o == 7'h5D, "R5 mode 1 pattern", int'(gate_o), 'h5D);

    set4(1601, 1599, 1600, 1600);              // average exactly upper
    idle(4);
    see_mode(1, "R3 upper boundary");

    set4(1600, 1600, 1600, 1599);              // floor gives 1599
    idle(8);
    chk(mode_o == 2'd2, "R2 floor average", int'(mode_o), 2);

    set4(2000, 2000, 2000, 2000);              // upward target while discharging
    idle(6);
    chk(mode_o == 2'd2, "R7 discharge ignores upward", int'(mode_o), 2);

    set4(900, 900, 900, 900);                  // single-tick glitch
    idle(1);
    set4(1300, 1300, 1300, 1300);
    idle(4);
    chk(mode_o == 2'd2, "R8 glitch rejected", int'(mode_o), 2);

    chg = 1'b1;                                // reverse rotation
    idle(6);
    chk(mode_o == 2'd2, "R9 charge rotation", int'(mode_o), 2);

    set4(900, 900, 900, 900);                  // downward target while charging
    idle(4);
    chk(mode_o == 2'd2, "R7 charge ignores downward", int'(mode_o), 2);

    set4(1700, 1700, 1700, 1700);
    idle(5);
    see_mode(1, "R10 leave from any sub-mode");

    chg = 1'b0;
    set4(1070, 1070, 1071, 1069);              // average exactly lower
    idle(6);
    chk(mode_o == 2'd2, "R3 lower boundary", int'(mode_o), 2);

    set4(1070, 1069, 1068, 1069);              // average 1069
    idle(6);
    see_mode(3, "R3 below lower");
    chk(gate_o == 7'h2A, "R5 mode 3 pattern", int'(gate_o), 'h2A);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

    // second run: start straight into mode 2 while charging
    @(negedge clk) rst_n = 1'b0;
    exp_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
    chk({gate_o, mode_o, sub_o, dead_o} == '0, "R1 reset again",
        int'({gate_o, mode_o, sub_o, dead_o}), 0);
    chg = 1'b1;
    set4(1300, 1310, 1290, 1300);
    rst_n = 1'b1;
    idle(5);
    chk(mode_o == 2'd2, "R10 charge entry", int'(mode_o), 2);
    set4(2000, 2000, 2000, 2000);
    idle(6);
    see_mode(1, "R7 charge step to mode 1");
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    finish_run();
  end

endmodule